// File: doc/BRIEF.md
# Masked Error Input Status Capture

This block collects fault indications from a small group of active-low error lines and from eight general-purpose pins, and latches each into a sticky status bit that software reads and clears over a simple parallel register bus. Any active-low source may drive the error lines. A low level, once synchronized, sets the matching bit. The bit stays set until software writes a one to its position.

Each of the eight general-purpose pins has its own direction bit and output value bit. A pin set as an input can also act as an error source: a low level on it sets its pin-status bit unless that pin's mask bit blocks it. A pin set as an output never sets a status bit, whatever its mask holds. All asynchronous inputs pass through a two-flop synchronizer before the status logic sees them. A single interrupt output is high whenever any status bit is set that its mask does not hide.

The bus is a plain single-cycle interface. A write with `bus_sel` and `bus_we` high takes effect on the next rising clock edge. Read data is a combinational decode of `bus_addr` from registered state. The external reset is asynchronous and active low, and the block releases it internally on the second rising edge after it goes high.

Top module: `fault_status_hub`

## Requirements
- R1: A low level on error line i, once synchronized, sets bit i of the error-status register at address 4. Bits at and above the number of error lines read as 0.
- R2: A level change on `err_n` or `pin_in` that is stable before rising edge k first affects status on the register update at edge k+2, so it is visible after that edge. A low pulse that spans one rising edge is captured.
- R3: Status bits are sticky and stay set after the source returns high. Writing 1 to a bit position of address 3 (pins) or address 4 (error lines) clears that bit. Writing 0 leaves the bit unchanged.
- R4: When a set event and a clear write reach the same status bit in the same cycle, the bit ends up set.
- R5: Address 0 holds the per-pin direction (bit n = 1 makes pin n an output) and drives `pin_oe`. Address 1 holds the per-pin output value and drives `pin_out`. Each bit is written independently through a full-byte write and reads back as written.
- R6: For a pin whose direction bit is 0 and whose mask bit is 0, a synchronized low level on `pin_in[n]` sets bit n of the pin-status register at address 3.
- R7: Address 2 holds the per-pin mask. A mask bit of 1 stops its pin from setting its pin-status bit.
- R8: A pin whose direction bit is 1 never sets its pin-status bit, regardless of its mask bit or its input level.
- R9: `irq` is 1 exactly when some pin-status bit is set whose mask bit is 0, or when any error-status bit is set.
- R10: Address 5 reads the synchronized level of the eight pins. Addresses 6 and 7 read 0. Reads have no side effect.
- R11: While reset is asserted and for two rising edges after release, direction and output value are 0, the mask is all ones, both status registers are 0, `irq` is 0, and bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| err_n | input | NUM_ERR | Active-low error lines |
| pin_in | input | 8 | General-purpose pin input levels |
| pin_out | output | 8 | General-purpose pin output values |
| pin_oe | output | 8 | General-purpose pin output enables (direction) |
| irq | output | 1 | Aggregate interrupt flag |

## Verification
A wrong internal state in this block reaches the ports quickly. A bad synchronizer stage or a wrong set condition changes the pin or error status readback, and `irq`, no more than three rising edges after the input changes. A lost sticky bit or a clear that is decoded wrongly shows up in the next read of address 3 or 4 and in `irq` in the same cycle. The bench therefore compares every register read and every output against a behavioural model on every clock, while it sweeps the read address, so a single-cycle deviation is flagged close to where it arises.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_DIR   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_OUT   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_PSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] REG_ESTAT = 3'd4;
  localparam logic [ADDR_W-1:0] REG_PLVL  = 3'd5;
endpackage

// File: rtl/fsh_rst_sync.sv
module fsh_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/fsh_sync2.sv
module fsh_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  // Idle level of active-low sources is high, so reset to all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      safe_q <= '1;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/fsh_sticky.sv
module fsh_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      stat_d[b] = stat_q[b];
      if (clr_i[b]) stat_d[b] = 1'b0;
      if (set_i[b]) stat_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R3: a set bit survives any cycle without a clear request
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));

  // R4: a set request always leaves the bit set, clear or not
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~stat_q) == '0));

  // R3: a clear request without a set leaves the bit low
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_i) & ~$past(set_i)) & stat_q) == '0));
endmodule

// File: rtl/fsh_cfg_regs.sv
module fsh_cfg_regs
  import fsh_pkg::*;
#(
  parameter int NUM_PIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_PIN-1:0] wdata_i,
  output logic [NUM_PIN-1:0] dir_o,
  output logic [NUM_PIN-1:0] out_o,
  output logic [NUM_PIN-1:0] mask_o
);
  logic [NUM_PIN-1:0] dir_q,  dir_d;
  logic [NUM_PIN-1:0] out_q,  out_d;
  logic [NUM_PIN-1:0] mask_q, mask_d;
  logic dir_en, out_en, mask_en;

  always_comb begin
    dir_en  = wr_en_i && (addr_i == REG_DIR);
    out_en  = wr_en_i && (addr_i == REG_OUT);
    mask_en = wr_en_i && (addr_i == REG_MASK);
    dir_d   = dir_en  ? wdata_i : dir_q;
    out_d   = out_en  ? wdata_i : out_q;
    mask_d  = mask_en ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '1;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      mask_q <= mask_d;
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign mask_o = mask_q;

  // R5: a direction write lands exactly as written
  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_DIR) |=> (dir_q == $past(wdata_i)));

  // R7: the mask only moves on a mask write
  assert_mask_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == REG_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/fault_status_hub.sv
module fault_status_hub
  import fsh_pkg::*;
#(
  parameter int NUM_PIN = 8,
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_PIN-1:0] bus_wdata,
  output logic [NUM_PIN-1:0] bus_rdata,
  input  logic [NUM_ERR-1:0] err_n,
  input  logic [NUM_PIN-1:0] pin_in,
  output logic [NUM_PIN-1:0] pin_out,
  output logic [NUM_PIN-1:0] pin_oe,
  output logic               irq
);
  localparam int DATA_W = NUM_PIN;

  logic               rst_n;
  logic               wr_en;
  logic [NUM_PIN-1:0] pin_dir, pin_val, pin_mask;
  logic [NUM_PIN-1:0] pin_sync, pin_set, pin_clr, pin_st;
  logic [NUM_ERR-1:0] err_sync, err_set, err_clr, err_st;
  logic [DATA_W-1:0]  err_st_ext;

  fsh_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign wr_en = bus_sel && bus_we;

  fsh_cfg_regs #(.NUM_PIN(NUM_PIN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .dir_o   (pin_dir),
    .out_o   (pin_val),
    .mask_o  (pin_mask)
  );

  fsh_sync2 #(.W(NUM_PIN)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (pin_sync)
  );

  fsh_sync2 #(.W(NUM_ERR)) u_err_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (err_n),
    .q_o   (err_sync)
  );

  always_comb begin
    pin_set = ~pin_sync & ~pin_dir & ~pin_mask;
    err_set = ~err_sync;
    pin_clr = (wr_en && bus_addr == REG_PSTAT) ? bus_wdata : '0;
    err_clr = (wr_en && bus_addr == REG_ESTAT) ? bus_wdata[NUM_ERR-1:0] : '0;
  end

  fsh_sticky #(.W(NUM_PIN)) u_pin_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pin_set),
    .clr_i  (pin_clr),
    .stat_o (pin_st)
  );

  fsh_sticky #(.W(NUM_ERR)) u_err_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .stat_o (err_st)
  );

  always_comb begin
    err_st_ext = '0;
    err_st_ext[NUM_ERR-1:0] = err_st;
  end

  always_comb begin
    unique case (bus_addr)
      REG_DIR:   bus_rdata = pin_dir;
      REG_OUT:   bus_rdata = pin_val;
      REG_MASK:  bus_rdata = pin_mask;
      REG_PSTAT: bus_rdata = pin_st;
      REG_ESTAT: bus_rdata = err_st_ext;
      REG_PLVL:  bus_rdata = pin_sync;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = pin_val;
  assign pin_oe  = pin_dir;
  assign irq     = (|(pin_st & ~pin_mask)) | (|err_st);

  // R8: an output pin's status bit never rises
  assert_output_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pin_dir) & ~$past(pin_st)) & pin_st) == '0));

  // R7: a masked pin's status bit never rises
  assert_masked_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pin_mask) & ~$past(pin_st)) & pin_st) == '0));

  // R9: interrupt low means no error-line status pending
  assert_irq_covers_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (err_st == '0));

  // R11: nothing is pending in the first active cycle after reset release
  assert_reset_clean_R11: assert property (@(posedge clk)
    !rst_n |=> (!irq && pin_st == '0 && err_st == '0));
endmodule

// File: tb/fault_status_hub_tb.sv
module fault_status_hub_tb_top;
  localparam int NP = 8;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NE-1:0] err_n = '1;
  logic [NP-1:0] pin_in = '1;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  always #2.5 clk = ~clk;

  fault_status_hub #(.NUM_PIN(NP), .NUM_ERR(NE)) dut_i (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_n(err_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  // Behavioural reference model
  logic [NP-1:0] m_dir, m_out, m_mask, m_pst, m_s1, m_s2;
  logic [NE-1:0] m_est, m_e1, m_e2;
  int            m_rel;
  int            n_vec = 0, n_bad = 0;
  string         phase = "R11";

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_dir = '0; m_out = '0; m_mask = '1; m_pst = '0; m_est = '0;
      m_s1 = '1; m_s2 = '1; m_e1 = '1; m_e2 = '1; m_rel = 0;
    end else begin
      if (m_rel >= 2) begin
        logic [NP-1:0] pset, pclr;
        logic [NE-1:0] eset, eclr;
        logic          wr;
        wr   = bus_sel && bus_we;
        pset = ~m_s2 & ~m_dir & ~m_mask;
        eset = ~m_e2;
        pclr = (wr && bus_addr == 3'd3) ? bus_wdata : '0;
        eclr = (wr && bus_addr == 3'd4) ? bus_wdata[NE-1:0] : '0;
        m_pst = (m_pst & ~pclr) | pset;
        m_est = (m_est & ~eclr) | eset;
        if (wr && bus_addr == 3'd0) m_dir  = bus_wdata;
        if (wr && bus_addr == 3'd1) m_out  = bus_wdata;
        if (wr && bus_addr == 3'd2) m_mask = bus_wdata;
        m_s2 = m_s1; m_s1 = pin_in;
        m_e2 = m_e1; m_e1 = err_n;
      end
      if (m_rel < 2) m_rel++;
    end
  end

  function automatic logic [NP-1:0] exp_rd(input logic [2:0] a);
    logic [NP-1:0] ext;
    ext = '0;
    ext[NE-1:0] = m_est;
    case (a)
      3'd0: return m_dir;
      3'd1: return m_out;
      3'd2: return m_mask;
      3'd3: return m_pst;
      3'd4: return ext;
      3'd5: return m_s2;
      default: return '0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R5";
      3'd2: return "R7";
      3'd3: return "R6";
      3'd4: return "R1";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    logic [NP-1:0] er;
    logic          ei;
    er = exp_rd(bus_addr);
    ei = (|(m_pst & ~m_mask)) | (|m_est);
    n_vec++;
    if (bus_rdata !== er) begin
      n_bad++;
      $display("FAIL %s/%s rdata addr %0d: got %h expected %h",
               phase, addr_tag(bus_addr), bus_addr, bus_rdata, er);
    end
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL %s/R9 irq: got %b expected %b", phase, irq, ei);
    end
    if (pin_oe !== m_dir || pin_out !== m_out) begin
      n_bad++;
      $display("FAIL %s/R5 pins: got oe %h out %h expected oe %h out %h",
               phase, pin_oe, pin_out, m_dir, m_out);
    end
  endtask

  // One cycle: compare at negedge, then drive the next bus request
  task automatic step(input logic we, input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    compare();
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'(i % 8), '0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    step(1'b1, a, d);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    // R11: reset values, writes ignored during reset and release window
    phase = "R11";
    repeat (3) @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hFF;
    @(negedge clk);
    arst_n = 1'b1;
    step(1'b1, 3'd1, 8'hFF);
    step(1'b1, 3'd2, 8'h00);
    idle(10);

    // R1, R2: single-cycle low pulse on error line 2 is captured
    phase = "R2";
    @(negedge clk);
    compare();
    err_n = 4'b1011;
    @(negedge clk);
    compare();
    err_n = 4'b1111;
    idle(8);

    // R3: writing 0 keeps, writing 1 clears
    phase = "R3";
    wr(3'd4, 8'h00);
    idle(3);
    wr(3'd4, 8'h04);
    idle(4);

    // R4: held error plus clear in same cycle, set wins
    phase = "R4";
    err_n = 4'b0110;
    idle(5);
    wr(3'd4, 8'hFF);
    idle(3);
    err_n = 4'b1111;
    idle(4);
    wr(3'd4, 8'hFF);
    idle(3);

    // R5: direction and output values
    phase = "R5";
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'h3C);
    idle(8);

    // R6: unmasked inputs set status, R8: outputs do not
    phase = "R6";
    wr(3'd2, 8'h00);
    pin_in = 8'h00;
    idle(8);
    phase = "R8";
    wr(3'd3, 8'hFF);
    idle(8);
    pin_in = 8'hFF;
    wr(3'd3, 8'hFF);
    idle(4);

    // R7: masked inputs do not set
    phase = "R7";
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hF0);
    pin_in = 8'h0F;
    idle(6);
    pin_in = 8'h00;
    idle(6);

    // R9: raising a mask hides a set pin bit from irq
    phase = "R9";
    pin_in = 8'hFF;
    idle(3);
    wr(3'd2, 8'hFF);
    idle(8);
    wr(3'd3, 8'hFF);
    idle(4);

    // R10: level readback and unused addresses
    phase = "R10";
    pin_in = 8'h96;
    idle(16);

    // Mixed traffic
    phase = "R6";
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 0) pin_in = 8'($urandom);
      if (i % 11 == 0) err_n = NE'($urandom) | NE'($urandom);
      if ($urandom_range(0, 3) == 0)
        wr(3'($urandom_range(0, 7)), 8'($urandom));
      else
        step(1'b0, 3'($urandom_range(0, 7)), '0);
    end

    // R11: reset in the middle of activity
    phase = "R11";
    @(negedge clk);
    arst_n = 1'b0;
    @(negedge clk);
    arst_n = 1'b1;
    bus_sel = 1'b0;
    idle(12);

    finish_run();
  end
endmodule